// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a supervision timer that resets the system when software stops servicing it. A counter of `CNT_W` bits (16 by default) advances once every D oscillator clocks. D is a power of two from 8 to 1024 and is picked by a 3-bit select field. When the counter steps past its all-ones value, the block raises a reset request for a fixed `PULSE_LEN` oscillator clocks (24 by default). Software keeps the system alive by writing the restart bit often enough. That write zeroes both the counter and the prescaler.

Two byte-wide registers are reached through a simple write strobe and a one-bit address. Address 0 is the control register: the enable, the restart command and the divider select. Address 1 is the status register. It holds a cause flag that the block sets when it fires, so software can see after a restart that the watchdog caused it. The block's own reset request acts as a system reset for the control register: enable and select both return to zero. The flag survives that request. Only the external hardware reset, or a software write of 0, clears it.

The sequencing is a three-state machine:
- OFF: the counter is not running.
- RUN: the block is counting.
- FIRE: the reset request is driven.

The transitions are:
- OFF→RUN when the enable bit is set.
- RUN→OFF when software clears the enable bit.
- OFF/RUN→FIRE on a counter wrap that is not cancelled by a simultaneous restart.
- FIRE→OFF after `PULSE_LEN` cycles.

Top module: `wdog_top`

## Requirements
- R1: When `ext_rst_n` is low, the control and status registers read 0x00 and `wdt_rst_req` is low.
- R2: In the control register, bit 7 is the enable and bits 2..0 are the divider select. Both read back as written. Bits 6, 4 and 3 read 0. Bit 5 is the restart command and always reads 0.
- R3: Consider a control write that sets enable and restart together on clock edge E0. `wdt_rst_req` first reads high right after edge E0 + D·2^CNT_W, where D = 2^(select+3). Select 000 gives 8 and select 111 gives 1024.
- R4: Each reset request stays high for exactly `PULSE_LEN` consecutive cycles, then returns low.
- R5: A watchdog firing clears the enable bit and the select field, so the control register reads 0x00 afterwards.
- R6: A firing sets status bit 7, and that bit stays set after the request ends. A status write with bit 7 = 0 clears it. A status write with bit 7 = 1 leaves it unchanged. `ext_rst_n` low clears it.
- R7: A restart write in mid-count zeroes the counter and the prescaler. The next request then comes a full D·2^CNT_W cycles after the restart edge.
- R8: A restart write on the very edge on which the counter would wrap wins: no request is raised, and a full new period begins.
- R9: Clearing the enable bit freezes the counter and the prescaler. Setting it again without restart resumes from the frozen count.
- R10: Register writes made while `wdt_rst_req` is high are ignored.
- R11: `reg_addr` = 0 selects the control register and `reg_addr` = 1 selects the status register, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| ext_rst_n | input | 1 | External hardware reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
The counter wrap and a software restart can land on the same edge. This is the race R8 settles. The bench provokes it by scheduling the restart write so that its edge is exactly the D·2^CNT_W-th edge after enabling. It then judges the outcome by seeing the request stay low on that edge, and rise only one full period later. A second coincidence is a register write while the request is active. That write must leave both registers untouched, and the bench reads them back once the pulse is over.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    localparam logic REG_CTL  = 1'b0;
    localparam logic REG_STAT = 1'b1;

    localparam int CTL_EN_BIT      = 7;
    localparam int CTL_RESTART_BIT = 5;
    localparam int STAT_FLAG_BIT   = 7;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int SEL_W    = 3,
    parameter int MIN_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = MIN_LOG2 + (1 << SEL_W) - 1;
    localparam logic [SEL_W-1:0] SEL_MAX = '1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // divider D = 2^(sel+MIN_LOG2); terminal value D-1
    always_comb begin
        limit = {PRE_W{1'b1}} >> (SEL_MAX - sel);
        tick  = run && (pre_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (run)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    always_comb wrap = tick && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [7:0]       wdata,
    input  logic             lock,
    input  logic             fire,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             flag_q,
    output logic             restart,
    output logic [7:0]       rdata
);
    logic ctl_wr;
    logic stat_wr;

    always_comb begin
        ctl_wr  = wr && !lock && (addr == REG_CTL);
        stat_wr = wr && !lock && (addr == REG_STAT);
        restart = ctl_wr && wdata[CTL_RESTART_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            sel_q  <= '0;
            flag_q <= 1'b0;
        end else if (fire) begin
            en_q   <= 1'b0;
            sel_q  <= '0;
            flag_q <= 1'b1;
        end else begin
            if (ctl_wr) begin
                en_q  <= wdata[CTL_EN_BIT];
                sel_q <= wdata[SEL_W-1:0];
            end
            if (stat_wr && !wdata[STAT_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == REG_CTL) begin
            rdata[CTL_EN_BIT] = en_q;
            rdata[SEL_W-1:0]  = sel_q;
        end else begin
            rdata[STAT_FLAG_BIT] = flag_q;
        end
    end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SEL_W     = 3,
    parameter int MIN_LOG2  = 3,
    parameter int PULSE_LEN = 24
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wdt_rst_req
);
    localparam int PW = $clog2(PULSE_LEN);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LEN - 1);

    wd_state_e        state_q, state_d;
    logic [PW-1:0]    pulse_q;
    logic             en_q, flag_q, restart;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick, wrap, run, lock, fire_go, clr;

    always_comb begin
        lock    = (state_q == ST_FIRE);
        run     = en_q && !lock;
        fire_go = wrap && !restart;
        clr     = restart || fire_go;
    end

    wdog_regs #(.SEL_W(SEL_W)) regs_i (
        .clk     (clk),
        .rst_n   (ext_rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .lock    (lock),
        .fire    (fire_go),
        .en_q    (en_q),
        .sel_q   (sel_q),
        .flag_q  (flag_q),
        .restart (restart),
        .rdata   (reg_rdata)
    );

    wdog_prescaler #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) pre_i (
        .clk   (clk),
        .rst_n (ext_rst_n),
        .clr   (clr),
        .run   (run),
        .sel   (sel_q),
        .tick  (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (ext_rst_n),
        .clr   (clr),
        .tick  (tick),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (fire_go) state_d = ST_FIRE;
                     else if (en_q) state_d = ST_RUN;
            ST_RUN:  if (fire_go) state_d = ST_FIRE;
                     else if (!en_q) state_d = ST_OFF;
            ST_FIRE: if (pulse_q == PULSE_LAST) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register and pulse timer
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state_q <= ST_OFF;
            pulse_q <= '0;
        end else begin
            state_q <= state_d;
            pulse_q <= (state_q == ST_FIRE) ? pulse_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb wdt_rst_req = (state_q == ST_FIRE);

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             en,
    input logic             flag,
    input logic             restart,
    input logic [CNT_W-1:0] cnt
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= '0;
        else if (req)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    // R3
    wrap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(cnt) == {CNT_W{1'b1}}));

    // R4
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (run_len < 16'(PULSE_LEN)));

    // R4
    pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (run_len == 16'(PULSE_LEN)));

    // R5
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !en);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> flag);

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !req && !restart) |=> $stable(cnt));

endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chk_i (
    .clk     (clk),
    .rst_n   (ext_rst_n),
    .req     (wdt_rst_req),
    .en      (en_q),
    .flag    (flag_q),
    .restart (restart),
    .cnt     (cnt_q)
);

// File: tb/wdog_top_test.sv
module wdog_top_test;
    localparam int CLK_P   = 10;
    localparam int CNT_W   = 4;
    localparam int PLEN    = 24;
    localparam int PERIOD0 = 8 * (1 << CNT_W);

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    wdog_top #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) uut (
        .clk(clk), .ext_rst_n(ext_rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write on one edge; returns at the falling edge after it
    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse_len(output int len);
        len = 0;
        while (wdt_rst_req === 1'b1 && len < 100) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        ext_rst_n = 1'b0;
        skip(3);
        ext_rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] v;
        int len;
        int n;
        skip(3);
        // R1 reset state
        rd_reg(1'b0, v); check("R1 ctrl during reset", v, 8'h00);
        rd_reg(1'b1, v); check("R1 status during reset", v, 8'h00);
        check("R1 req during reset", wdt_rst_req, 1'b0);
        ext_rst_n = 1'b1;
        skip(2);

        // R11 address decode, R2 field layout
        wr_reg(1'b0, 8'h83);
        rd_reg(1'b0, v); check("R11 ctrl at addr 0", v, 8'h83);
        rd_reg(1'b1, v); check("R11 status at addr 1", v, 8'h00);
        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, v); check("R2 unused and restart read 0", v, 8'h87);
        wr_reg(1'b0, 8'h5D);
        rd_reg(1'b0, v); check("R2 enable low, select 5", v, 8'h05);
        do_reset();

        // R3 R4 R5 R6 sweep over every divider select
        for (int s = 0; s < 8; s++) begin
            n = (8 << s) * (1 << CNT_W);
            wr_reg(1'b0, 8'hA0 | 8'(s));
            skip(n - 1);
            check($sformatf("R3 sel=%0d low one cycle before", s), wdt_rst_req, 1'b0);
            skip(1);
            check($sformatf("R3 sel=%0d request at period", s), wdt_rst_req, 1'b1);
            pulse_len(len);
            check($sformatf("R4 sel=%0d pulse length", s), len, PLEN);
            rd_reg(1'b0, v); check($sformatf("R5 sel=%0d ctrl cleared", s), v, 8'h00);
            rd_reg(1'b1, v); check($sformatf("R6 sel=%0d flag set", s), v, 8'h80);
            wr_reg(1'b1, 8'h80);
            rd_reg(1'b1, v); check("R6 write 1 keeps flag", v, 8'h80);
            wr_reg(1'b1, 8'h7F);
            rd_reg(1'b1, v); check("R6 write 0 clears flag", v, 8'h00);
        end

        // R10 writes during pulse are ignored
        wr_reg(1'b0, 8'hA0);
        skip(PERIOD0);
        check("R10 request active", wdt_rst_req, 1'b1);
        wr_reg(1'b0, 8'h83);
        wr_reg(1'b1, 8'h00);
        skip(PLEN + 4);
        rd_reg(1'b0, v); check("R10 ctrl write ignored", v, 8'h00);
        rd_reg(1'b1, v); check("R10 status write ignored", v, 8'h80);

        // R7 restart in mid-count
        wr_reg(1'b0, 8'hA0);
        skip(100);
        wr_reg(1'b0, 8'hA0);
        skip(PERIOD0 - 1);
        check("R7 no request before full period", wdt_rst_req, 1'b0);
        skip(1);
        check("R7 request one period after restart", wdt_rst_req, 1'b1);
        skip(PLEN + 4);

        // R8 restart on the wrap edge
        wr_reg(1'b0, 8'hA0);
        skip(PERIOD0 - 2);
        wr_reg(1'b0, 8'hA0);
        check("R8 restart beats wrap", wdt_rst_req, 1'b0);
        skip(PERIOD0 - 1);
        check("R8 no early request", wdt_rst_req, 1'b0);
        skip(1);
        check("R8 request one period later", wdt_rst_req, 1'b1);
        skip(PLEN + 4);

        // R9 disable freezes, re-enable resumes
        wr_reg(1'b0, 8'hA0);
        skip(48);
        wr_reg(1'b0, 8'h00);
        skip(200);
        check("R9 no request while disabled", wdt_rst_req, 1'b0);
        wr_reg(1'b0, 8'h80);
        skip(PERIOD0 - 50 - 1);
        check("R9 resumed count not yet done", wdt_rst_req, 1'b0);
        skip(1);
        check("R9 resumed count fires", wdt_rst_req, 1'b1);
        skip(PLEN + 4);

        // R6 R1 external reset clears flag
        rd_reg(1'b1, v); check("R6 flag before external reset", v, 8'h80);
        do_reset();
        rd_reg(1'b1, v); check("R6 external reset clears flag", v, 8'h00);
        rd_reg(1'b0, v); check("R1 ctrl after external reset", v, 8'h00);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule